// File: doc/BRIEF.md
# Data-Side Translation Lookup with Fault Status Capture

This block looks up each data access in a fully associative translation buffer and records what went wrong when the access cannot proceed. Each access carries a virtual address, an access class, a store flag, a user-mode flag and the current processor privilege state. The access class picks the context that the lookup uses. The buffer compares the virtual page number and that context against all entries in parallel.

There are three outcomes. A match that is allowed gives a hit pulse. A user-mode access that matches an entry marked privileged gives a data-fault trap. In that case a status word is built and latched, and the faulting address is latched with it. An access that matches nothing gives a miss trap. A miss loads only the tag-access register and leaves the status and fault-address registers untouched.

A software strobe consumes the recorded fault by clearing its valid bit. If a second fault arrives before that strobe, the new status word carries an overwrite flag. Buffer entries are written through a simple indexed load port. The logic that decides what to load there sits outside this block.

Top module: `mmu_fault_capture`

## Requirements
- R1: An access hits when a valid entry holds its virtual page number (address bits above bit 12) and the selected context. Class 0 selects the primary context input, class 1 selects the secondary context input, and classes 2 and 3 (nucleus) select context 0. All entries are searched, including the last index.
- R2: A user-mode access (`acc_user`=1) that matches an entry whose privileged flag is set produces `fault_o` with `trap_code` = 8'h30. The same match from kernel mode (`acc_user`=0) is an ordinary hit with `trap_code` = 0.
- R3: On a fault the status word holds the following: valid at bit 0, write at bit 2 (set for a store), privilege-mode at bit 3 (equal to `pstate_priv`), the context-type field at bits 5:4 (0 for primary, 1 for secondary, 2 for nucleus classes 2 and 3), and the privilege-violation fault type at bit 7. All other bits are zero.
- R4: The overwrite bit (bit 1) of a newly recorded status word is set exactly when the valid bit was already set at the time of the fault.
- R5: On a fault `far_o` is loaded with the full faulting virtual address.
- R6: On a miss `miss_o` pulses with `trap_code` = 8'h68. `tag_access_o` is loaded with the address with its low 13 bits cleared, ORed with the selected context. `fsr_o` and `far_o` keep their values.
- R7: The `fsr_clear` strobe clears only bit 0 of the status word. When it coincides with a fault, the fault is recorded and its overwrite bit is 0.
- R8: The `hit_o`, `fault_o` and `miss_o` pulses appear in the cycle after the access is presented, at most one at a time. `trap_code` is zero unless a fault or miss pulse is present.
- R9: After reset all outputs and registers are zero and every buffer entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ent_we | input | 1 | Write one buffer entry |
| ent_idx | input | 6 | Index of the entry to write |
| ent_vpn | input | 51 | Virtual page number for the entry |
| ent_ctx | input | 13 | Context for the entry |
| ent_priv | input | 1 | Entry is privileged-only |
| ctx_primary | input | 13 | Primary context value |
| ctx_secondary | input | 13 | Secondary context value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_va | input | 64 | Access virtual address |
| acc_class | input | 2 | 0 primary, 1 secondary, 2/3 nucleus |
| acc_user | input | 1 | Access issued in user mode |
| acc_write | input | 1 | Access is a store |
| pstate_priv | input | 1 | Processor privilege state |
| fsr_clear | input | 1 | Software consumed the status word |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Privilege fault recorded |
| miss_o | output | 1 | No entry matched |
| trap_code | output | 8 | Trap number for fault or miss |
| fsr_o | output | 16 | Fault status register |
| far_o | output | 64 | Fault address register |
| tag_access_o | output | 64 | Tag-access register |

## Verification
The hardest case to reach is the overwrite flag and how it interacts with the clear strobe. This needs two faults in a row, with the valid bit still set from the first. It also needs the clear strobe to land either in an earlier cycle or in the very cycle of the second fault. The stimulus table chains faults across different classes without clearing, then inserts a clear before one of them. Directed steps then raise the strobe together with a fault, and send a miss straight after a recorded fault to show the status word is left as it was.

// File: rtl/mmu_fsr_pkg.sv
package mmu_fsr_pkg;

  localparam int FSR_W = 16;

  localparam int FSR_VALID  = 0;
  localparam int FSR_OVWR   = 1;
  localparam int FSR_WRITE  = 2;
  localparam int FSR_PMODE  = 3;
  localparam int FSR_CT_LO  = 4;
  localparam int FSR_FT_PRV = 7;

  typedef enum logic [1:0] {
    CT_PRIMARY   = 2'd0,
    CT_SECONDARY = 2'd1,
    CT_NUCLEUS   = 2'd2
  } ctx_type_e;

  // Assemble a status word for a privilege fault.
  function automatic logic [FSR_W-1:0] build_fsr(
    input ctx_type_e ct,
    input logic      is_store,
    input logic      pmode,
    input logic      ovwr
  );
    logic [FSR_W-1:0] w;
    w                      = '0;
    w[FSR_VALID]           = 1'b1;
    w[FSR_OVWR]            = ovwr;
    w[FSR_WRITE]           = is_store;
    w[FSR_PMODE]           = pmode;
    w[FSR_CT_LO+1:FSR_CT_LO] = ct;
    w[FSR_FT_PRV]          = 1'b1;
    return w;
  endfunction

  // Tag-access word: page bits kept, context placed in the offset field.
  function automatic logic [63:0] tag_word(
    input logic [63:0] va,
    input logic [63:0] ctx,
    input int unsigned page_w
  );
    logic [63:0] mask;
    mask = ~((64'd1 << page_w) - 64'd1);
    return (va & mask) | ctx;
  endfunction

endpackage

// File: rtl/mmu_ctx_select.sv
module mmu_ctx_select
  import mmu_fsr_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic [1:0]       cls,
  input  logic [CTX_W-1:0] primary,
  input  logic [CTX_W-1:0] secondary,
  output logic [CTX_W-1:0] ctx,
  output ctx_type_e        ct
);
  always_comb begin
    unique case (cls)
      2'd0: begin ctx = primary;   ct = CT_PRIMARY;   end
      2'd1: begin ctx = secondary; ct = CT_SECONDARY; end
      default: begin ctx = '0;     ct = CT_NUCLEUS;   end
    endcase
  end
endmodule

// File: rtl/mmu_tlb_cam.sv
module mmu_tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 51,
  parameter int CTX_W   = 13,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic             wr_priv,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic             lk_hit,
  output logic             lk_priv
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] priv_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             vld_q;
    logic             prv_q;
    logic [VPN_W-1:0] vpn_q;
    logic [CTX_W-1:0] ctx_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        prv_q <= 1'b0;
        vpn_q <= '0;
        ctx_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        vld_q <= 1'b1;
        prv_q <= wr_priv;
        vpn_q <= wr_vpn;
        ctx_q <= wr_ctx;
      end
    end

    assign match_vec[i] = vld_q && (vpn_q == lk_vpn) && (ctx_q == lk_ctx);
    assign priv_vec[i]  = prv_q;
  end

  // Lowest matching index decides the privilege attribute.
  always_comb begin
    lk_priv = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) lk_priv = priv_vec[i];
    end
  end

  assign lk_hit = |match_vec;
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_fsr_pkg::*;
#(
  parameter int          VA_W       = 64,
  parameter int          PAGE_W     = 13,
  parameter int          CTX_W      = 13,
  parameter int          ENTRIES    = 64,
  parameter int          IDX_W      = $clog2(ENTRIES),
  parameter int          TRAP_W     = 8,
  parameter logic [7:0]  TRAP_FAULT = 8'h30,
  parameter logic [7:0]  TRAP_MISS  = 8'h68
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ent_we,
  input  logic [IDX_W-1:0]       ent_idx,
  input  logic [VA_W-PAGE_W-1:0] ent_vpn,
  input  logic [CTX_W-1:0]       ent_ctx,
  input  logic                   ent_priv,
  input  logic [CTX_W-1:0]       ctx_primary,
  input  logic [CTX_W-1:0]       ctx_secondary,
  input  logic                   acc_valid,
  input  logic [VA_W-1:0]        acc_va,
  input  logic [1:0]             acc_class,
  input  logic                   acc_user,
  input  logic                   acc_write,
  input  logic                   pstate_priv,
  input  logic                   fsr_clear,
  output logic                   hit_o,
  output logic                   fault_o,
  output logic                   miss_o,
  output logic [TRAP_W-1:0]      trap_code,
  output logic [FSR_W-1:0]       fsr_o,
  output logic [VA_W-1:0]        far_o,
  output logic [VA_W-1:0]        tag_access_o
);
  localparam int VPN_W = VA_W - PAGE_W;

  logic [CTX_W-1:0] sel_ctx;
  ctx_type_e        sel_ct;
  logic             lk_hit;
  logic             lk_priv;

  mmu_ctx_select #(.CTX_W(CTX_W)) u_ctx (
    .cls       (acc_class),
    .primary   (ctx_primary),
    .secondary (ctx_secondary),
    .ctx       (sel_ctx),
    .ct        (sel_ct)
  );

  mmu_tlb_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .CTX_W   (CTX_W),
    .IDX_W   (IDX_W)
  ) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ent_we),
    .wr_idx  (ent_idx),
    .wr_vpn  (ent_vpn),
    .wr_ctx  (ent_ctx),
    .wr_priv (ent_priv),
    .lk_vpn  (acc_va[VA_W-1:PAGE_W]),
    .lk_ctx  (sel_ctx),
    .lk_hit  (lk_hit),
    .lk_priv (lk_priv)
  );

  // Named events for the assertions and the register updates.
  logic             evt_fault;
  logic             evt_hit;
  logic             evt_miss;
  logic             prior_valid;
  logic [FSR_W-1:0] fsr_next;
  logic [VA_W-1:0]  tag_next;

  assign evt_fault   = acc_valid && lk_hit && lk_priv && acc_user;
  assign evt_hit     = acc_valid && lk_hit && !evt_fault;
  assign evt_miss    = acc_valid && !lk_hit;
  assign prior_valid = fsr_o[FSR_VALID] && !fsr_clear;
  assign fsr_next    = build_fsr(sel_ct, acc_write, pstate_priv, prior_valid);
  assign tag_next    = VA_W'(tag_word(64'(acc_va), 64'(sel_ctx), PAGE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      miss_o       <= 1'b0;
      trap_code    <= '0;
      fsr_o        <= '0;
      far_o        <= '0;
      tag_access_o <= '0;
    end else begin
      hit_o     <= evt_hit;
      fault_o   <= evt_fault;
      miss_o    <= evt_miss;
      trap_code <= evt_fault ? TRAP_W'(TRAP_FAULT) :
                   evt_miss  ? TRAP_W'(TRAP_MISS)  : '0;
      if (evt_fault) begin
        fsr_o <= fsr_next;
        far_o <= acc_va;
      end else if (fsr_clear) begin
        fsr_o[FSR_VALID] <= 1'b0;
      end
      if (evt_miss) tag_access_o <= tag_next;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_o, fault_o, miss_o})); // R8
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_code != '0) |-> (fault_o || miss_o)); // R8
  AST_FAULT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (fsr_o[FSR_VALID] && fsr_o[FSR_FT_PRV])); // R3
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (fsr_o[FSR_OVWR] == ($past(fsr_o[FSR_VALID]) && !$past(fsr_clear)))); // R4
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (far_o == $past(acc_va))); // R5
  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_o && !$past(fsr_clear)) |-> ($stable(fsr_o) && $stable(far_o))); // R6
endmodule

// File: tb/mmu_fault_capture_bench.sv
module mmu_fault_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ent_we = 1'b0;
  logic [5:0]  ent_idx = '0;
  logic [50:0] ent_vpn = '0;
  logic [12:0] ent_ctx = '0;
  logic        ent_priv = 1'b0;
  logic [12:0] ctx_primary = 13'd5;
  logic [12:0] ctx_secondary = 13'd9;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_va = '0;
  logic [1:0]  acc_class = '0;
  logic        acc_user = 1'b0;
  logic        acc_write = 1'b0;
  logic        pstate_priv = 1'b0;
  logic        fsr_clear = 1'b0;
  logic        hit_o, fault_o, miss_o;
  logic [7:0]  trap_code;
  logic [15:0] fsr_o;
  logic [63:0] far_o, tag_access_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmu_fault_capture u_mmu_fault_capture (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_idx(ent_idx),
    .ent_vpn(ent_vpn), .ent_ctx(ent_ctx), .ent_priv(ent_priv),
    .ctx_primary(ctx_primary), .ctx_secondary(ctx_secondary),
    .acc_valid(acc_valid), .acc_va(acc_va), .acc_class(acc_class),
    .acc_user(acc_user), .acc_write(acc_write), .pstate_priv(pstate_priv),
    .fsr_clear(fsr_clear), .hit_o(hit_o), .fault_o(fault_o), .miss_o(miss_o),
    .trap_code(trap_code), .fsr_o(fsr_o), .far_o(far_o),
    .tag_access_o(tag_access_o)
  );

  localparam logic [63:0] VA_A = 64'h0000_1234_5678_A123; // idx63 ctx5 user
  localparam logic [63:0] VA_B = 64'h0000_0000_0040_2007; // idx0  ctx9 priv
  localparam logic [63:0] VA_C = 64'hFFFF_F800_0000_5FFF; // idx30 ctx0 priv
  localparam logic [63:0] VA_U = 64'h0000_0ABC_0000_0055; // unmapped

  // {clr, cls[1:0], user, wr, ps, sel[1:0], outcome[1:0]}; outcome 0 hit 1 fault 2 miss
  localparam int NV = 10;
  localparam logic [9:0] VECS [NV] = '{
    10'b0_00_1_0_0_00_00,
    10'b0_01_1_1_0_01_01,
    10'b0_01_0_0_1_01_00,
    10'b0_10_1_0_1_10_01,
    10'b1_10_1_1_0_10_01,
    10'b0_00_1_0_0_11_10,
    10'b0_00_1_0_0_01_10,
    10'b0_10_0_0_0_00_10,
    10'b0_01_1_1_0_01_01,
    10'b0_00_0_1_1_00_00
  };

  logic [15:0] m_fsr = '0;
  logic [63:0] m_far = '0;

  function automatic logic [63:0] pick_va(input logic [1:0] s);
    case (s)
      2'd0: return VA_A;
      2'd1: return VA_B;
      2'd2: return VA_C;
      default: return VA_U;
    endcase
  endfunction

  function automatic logic [63:0] ctx_of(input logic [1:0] c);
    if (c == 2'd0) return 64'd5;
    if (c == 2'd1) return 64'd9;
    return 64'd0;
  endfunction

  function automatic logic [15:0] exp_word(input logic [1:0] c, input logic wr,
                                           input logic ps, input logic ow);
    int ct;
    ct = (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : 2;
    return 16'(1 + (ow ? 2 : 0) + (wr ? 4 : 0) + (ps ? 8 : 0) + ct * 16 + 128);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [63:0] va, input int ctx, input bit prv);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 6'(idx); ent_vpn = va[63:13];
    ent_ctx = 13'(ctx); ent_priv = prv;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic access(input logic [1:0] c, input bit u, input bit w, input bit p,
                        input logic [63:0] va, input bit clr);
    @(negedge clk);
    acc_valid = 1'b1; acc_class = c; acc_user = u; acc_write = w;
    pstate_priv = p; acc_va = va; fsr_clear = clr;
    @(negedge clk);
    acc_valid = 1'b0; fsr_clear = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    fsr_clear = 1'b1;
    @(negedge clk);
    fsr_clear = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({hit_o, fault_o, miss_o} == 3'b0, "R9 pulses", {hit_o, fault_o, miss_o}, 0);
    chk(fsr_o == 0 && far_o == 0 && tag_access_o == 0 && trap_code == 0,
        "R9 registers", fsr_o, 0);
    rst_n = 1'b1;
    // R9: empty buffer misses
    access(2'd0, 1'b1, 1'b0, 1'b0, VA_A, 1'b0);
    chk(miss_o, "R9 empty buffer miss", miss_o, 1);

    load(63, VA_A, 5, 1'b0);
    load(0,  VA_B, 9, 1'b1);
    load(30, VA_C, 0, 1'b1);
    m_fsr = fsr_o; m_far = far_o;

    for (int i = 0; i < NV; i++) begin
      logic [9:0]  v;
      logic [63:0] va;
      logic [1:0]  oc;
      v  = VECS[i];
      va = pick_va(v[3:2]);
      oc = v[1:0];
      if (v[9]) begin
        pulse_clear();
        m_fsr[0] = 1'b0;
      end
      access(v[8:7], v[6], v[5], v[4], va, 1'b0);
      chk({hit_o, fault_o, miss_o} == {oc == 2'd0, oc == 2'd1, oc == 2'd2},
          "R1 R2 outcome", {hit_o, fault_o, miss_o},
          {oc == 2'd0, oc == 2'd1, oc == 2'd2});
      if (oc == 2'd0) begin
        chk(trap_code == 0, "R8 hit trap code", trap_code, 0);
      end else if (oc == 2'd1) begin
        m_fsr = exp_word(v[8:7], v[5], v[4], m_fsr[0]);
        m_far = va;
        chk(trap_code == 8'h30, "R2 fault trap", trap_code, 8'h30);
        chk(fsr_o == m_fsr, "R3 R4 status word", fsr_o, m_fsr);
        chk(far_o == m_far, "R5 fault address", far_o, m_far);
      end else begin
        chk(trap_code == 8'h68, "R6 miss trap", trap_code, 8'h68);
        chk(tag_access_o == ((va & ~64'h1FFF) | ctx_of(v[8:7])), "R6 tag access",
            tag_access_o, (va & ~64'h1FFF) | ctx_of(v[8:7]));
        chk(fsr_o == m_fsr && far_o == m_far, "R6 status kept", fsr_o, m_fsr);
      end
    end

    // R8: idle cycle after access has no pulses
    @(negedge clk);
    chk({hit_o, fault_o, miss_o} == 0 && trap_code == 0, "R8 idle",
        {hit_o, fault_o, miss_o}, 0);

    // R7: clear in the same cycle as a fault gives no overwrite
    access(2'd1, 1'b1, 1'b0, 1'b0, VA_B, 1'b1);
    m_fsr = exp_word(2'd1, 1'b0, 1'b0, 1'b0);
    chk(fsr_o == m_fsr, "R7 clear with fault", fsr_o, m_fsr);

    // R7: clear alone drops only bit 0
    pulse_clear();
    m_fsr[0] = 1'b0;
    chk(fsr_o == m_fsr, "R7 clear only valid", fsr_o, m_fsr);

    // R3: class 3 is treated as nucleus, and fault after clear has no overwrite (R4)
    access(2'd3, 1'b1, 1'b1, 1'b1, VA_C, 1'b0);
    m_fsr = exp_word(2'd2, 1'b1, 1'b1, 1'b0);
    m_far = VA_C;
    chk(fsr_o == m_fsr, "R3 class3 nucleus", fsr_o, m_fsr);

    // R6: miss right after a fault leaves status and address alone
    access(2'd1, 1'b0, 1'b1, 1'b0, VA_U, 1'b0);
    chk(miss_o && fsr_o == m_fsr && far_o == m_far, "R6 miss after fault", fsr_o, m_fsr);
    chk(tag_access_o == ((VA_U & ~64'h1FFF) | 64'd9), "R6 secondary tag",
        tag_access_o, (VA_U & ~64'h1FFF) | 64'd9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule